// File: doc/BRIEF.md
# I2C Register Slave with Auto-Increment Addressing

This block sits on a two-wire serial bus as a slave and gives the bus master access to a register space of up to 32768 byte locations. It watches the clock and data lines, which arrive already synchronised to the system clock. It detects bus start and stop conditions and answers only to its own fixed 7-bit device identifier. It pulls the data line low through an open-drain enable, and never drives it high.

In a write, the master follows the identifier byte with a 16-bit internal address, high byte first. Bits 14:0 of that address pick the register. Bit 15 chooses whether the internal pointer steps forward after each data byte or stays where it is. Each data byte then appears on a simple register port as a one-cycle write strobe, together with the address and the data. A read returns bytes from the current pointer. A master can first set the pointer with an address-only write and then issue a repeated start to read from it. An input from the register side can refuse a written byte, and the slave then answers that byte with no acknowledge.

Top module: `i2c_regslave`

## Requirements
- R1: A start (data falling while clock is high) or a stop (data rising while clock is high) releases the data line on the next cycle. The slave then waits for a fresh identifier byte after a start and ignores the bus after a stop.
- R2: The first byte after a start is received MSB first. Its upper 7 bits are compared with DEV_ID (default 7'b1101010) and its LSB selects direction (1 read, 0 write). On a match, the slave pulls data low for the 9th clock.
- R3: On an identifier mismatch, the data line stays released for every later clock, and no register strobe occurs, until the next start or stop.
- R4: In a write, the two bytes after the identifier are acknowledged and form a 16-bit address. Bit 15 enables stepping, and bits 14:0 load the register pointer.
- R5: Each accepted data byte gives exactly one single-cycle reg_we pulse, with reg_wdata holding the byte and reg_addr holding the pointer, and the byte is acknowledged.
- R6: After each data byte written or read, the pointer advances by one when stepping is enabled and holds its value when it is not. The pointer keeps its value across stop conditions.
- R7: The pointer wraps from 0x7FFF to 0x0000.
- R8: When reg_ready is low at the end of a write data byte, the slave does not acknowledge the byte, no strobe occurs and the pointer does not move.
- R9: In a read, the slave sends reg_rdata for the current pointer MSB first, changing data only while the clock is low, and releases the line for the 9th clock.
- R10: When the master does not acknowledge a read byte, the slave leaves the data line released until the next start or stop.
- R11: A repeated start keeps the pointer and stepping mode, so a read after an address-only write begins at the address that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised bus clock level |
| sda_in | input | 1 | Synchronised bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | ADDR_W | Register pointer |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for reg_addr, valid in the same cycle |
| reg_ready | input | 1 | Register side accepts a written byte |

## Verification
The bench builds the block with its default parameters: a 15-bit pointer and the identifier 7'b1101010. With the full 15-bit pointer, the wrap from 0x7FFF to 0x0000 can be reached directly by writing address 0xFFFF and sending two data bytes. The bench uses the default identifier, so identifier bytes 0xD4 and 0xD5 match, and a byte built from 7'h55 exercises the mismatch path. The register side is modelled as a function of the address, so read data can be predicted at any pointer value, including after a stop or a repeated start.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int BYTE_W    = 8;
    localparam int PTR_FIELD = 15;
    localparam int ACK_SLOT  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } rs_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic id_hit(input logic [BYTE_W-1:0] b, input logic [6:0] id);
        return b[BYTE_W-1:1] == id;
    endfunction

endpackage

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond
    import i2c_rs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        evt.rise  = scl_in & ~scl_q;
        evt.fall  = ~scl_in & scl_q;
        evt.start = scl_in & scl_q & sda_q & ~sda_in;
        evt.stop  = scl_in & scl_q & ~sda_q & sda_in;
    end
endmodule

// File: rtl/i2c_rs_ctr.sv
module i2c_rs_ctr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_inc,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              inc_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            inc_en <= 1'b0;
        end else if (load) begin
            addr   <= load_addr;
            inc_en <= load_inc;
        end else if (adv && inc_en) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'b1101010,
    parameter int         ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata,
    input  logic              reg_ready
);
    localparam int CNT_W = $clog2(ACK_SLOT + 1);

    bus_evt_t            evt;
    rs_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic                acking, mack_wait;
    logic [BYTE_W-1:0]   rx_sh, tx_sh, hi_q;
    logic                oe_q, we_q, adv_q;
    logic [BYTE_W-1:0]   wdata_q;
    logic                active, byte_end, ptr_load, inc_en;
    logic [PTR_FIELD-1:0] full_addr;

    i2c_rs_cond u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    assign active    = (state != ST_IDLE) && (state != ST_IGNORE);
    assign byte_end  = active && evt.fall && (cnt == CNT_W'(ACK_SLOT)) && !acking;
    assign ptr_load  = byte_end && (state == ST_ADDR_LO);
    assign full_addr = {hi_q[6:0], rx_sh};

    i2c_rs_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_addr (full_addr[ADDR_W-1:0]),
        .load_inc  (hi_q[BYTE_W-1]),
        .adv       (adv_q),
        .addr      (reg_addr),
        .inc_en    (inc_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            acking    <= 1'b0;
            mack_wait <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            hi_q      <= '0;
            oe_q      <= 1'b0;
            we_q      <= 1'b0;
            adv_q     <= 1'b0;
            wdata_q   <= '0;
        end else begin
            we_q  <= 1'b0;
            adv_q <= 1'b0;
            if (evt.start || evt.stop) begin
                state     <= evt.start ? ST_DEVSEL : ST_IDLE;
                cnt       <= '0;
                acking    <= 1'b0;
                mack_wait <= 1'b0;
                oe_q      <= 1'b0;
            end else if (active) begin
                if (evt.rise) begin
                    if (cnt != CNT_W'(ACK_SLOT)) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                        cnt   <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        if (mack_wait) begin
                            mack_wait <= 1'b0;
                            if (sda_in) state <= ST_IGNORE;
                        end
                    end
                end
                if (byte_end) begin
                    acking <= 1'b1;
                    unique case (state)
                        ST_DEVSEL: begin
                            oe_q  <= id_hit(rx_sh, DEV_ID);
                            state <= !id_hit(rx_sh, DEV_ID) ? ST_IGNORE :
                                     rx_sh[0] ? ST_RDATA : ST_ADDR_HI;
                        end
                        ST_ADDR_HI: begin
                            oe_q  <= 1'b1;
                            hi_q  <= rx_sh;
                            state <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            oe_q  <= 1'b1;
                            state <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            oe_q    <= reg_ready;
                            we_q    <= reg_ready;
                            adv_q   <= reg_ready;
                            wdata_q <= rx_sh;
                        end
                        ST_RDATA: begin
                            oe_q      <= 1'b0;
                            adv_q     <= 1'b1;
                            mack_wait <= 1'b1;
                        end
                        default: oe_q <= 1'b0;
                    endcase
                end else if (evt.fall && cnt == '0 && acking) begin
                    acking <= 1'b0;
                    if (state == ST_RDATA) begin
                        tx_sh <= reg_rdata;
                        oe_q  <= ~reg_rdata[BYTE_W-1];
                    end else begin
                        oe_q <= 1'b0;
                    end
                end else if (evt.fall && state == ST_RDATA && cnt != '0) begin
                    oe_q <= ~tx_sh[3'd7 - cnt[2:0]];
                end
            end
        end
    end

    assign sda_oe    = oe_q;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_in,
    input logic              sda_in,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              reg_ready,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              inc_en
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_in;
            sda_p <= sda_in;
        end
    end

    // R1: start or stop releases the data line
    p_release_on_cond_r1: assert property (@(posedge clk) disable iff (rst)
        (scl_in && scl_p && (sda_in != sda_p)) |=> !sda_oe);

    // R5: write strobe lasts one cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R8: a strobe only follows a ready register side
    p_we_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(reg_ready));

    // R6, R7: pointer steps by one with wrap when stepping is on
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && inc_en) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

    // R6: pointer holds when stepping is off
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !inc_en) |=> $stable(reg_addr));

    // R9: the slave starts pulling only while the clock is low
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_in));
endmodule

bind i2c_regslave i2c_regslave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_ready (reg_ready),
    .reg_addr  (reg_addr),
    .inc_en    (inc_en)
);

// File: tb/i2c_regslave_tb_top.sv
module i2c_regslave_tb_top;
    localparam int ADDR_W = 15;
    localparam int Q      = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } wr_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_m = 1'b1, sda_m = 1'b1;
    logic              sda_line, sda_oe, reg_we, ready_m = 1'b1;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0]        reg_wdata, reg_rdata;
    int                total = 0, bad = 0, oe_high_rise = 0;
    logic              oe_prev = 1'b0;
    wr_t               exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [7:0] rd_f(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    assign reg_rdata = rd_f(reg_addr);

    i2c_regslave dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_ready (ready_m)
    );

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Scoreboard monitor: pops expected writes as strobes appear (R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe && !oe_prev && scl_m) oe_high_rise++;
            oe_prev <= sda_oe;
            if (reg_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R3/R8 unexpected write", int'(reg_addr), 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    chk(reg_addr == e.a, "R5 write addr", int'(reg_addr), int'(e.a));
                    chk(reg_wdata == e.d, "R5 write data", int'(reg_wdata), int'(e.d));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(negedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1; half(); half();
            scl_m = 1'b0; half();
        end
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        ack = sda_line; half();
        scl_m = 1'b0; half();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; half();
            scl_m = 1'b1; half();
            b = {b[6:0], sda_line}; half();
            scl_m = 1'b0; half();
        end
        sda_m = nack; half();
        scl_m = 1'b1; half(); half();
        scl_m = 1'b0; half();
        sda_m = 1'b1;
    endtask

    task automatic write_burst(input logic [15:0] a, input logic [7:0] d0, input int n, input string tag);
        logic ack;
        logic [ADDR_W-1:0] ea;
        ea = a[14:0];
        bus_start();
        send_byte(8'hD4, ack); chk(ack == 1'b0, {tag, " R2 id ack"}, ack, 0);
        send_byte(a[15:8], ack); chk(ack == 1'b0, {tag, " R4 addr hi ack"}, ack, 0);
        send_byte(a[7:0], ack);  chk(ack == 1'b0, {tag, " R4 addr lo ack"}, ack, 0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back('{a: ea, d: 8'(d0 + k)});
            send_byte(8'(d0 + k), ack);
            chk(ack == 1'b0, {tag, " R5 data ack"}, ack, 0);
            if (a[15]) ea = ea + 1'b1;
        end
        bus_stop();
        half();
        chk(exp_q.size() == 0, {tag, " R6 writes drained"}, exp_q.size(), 0);
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        half();
        chk(sda_oe == 1'b0, "R1 reset sda released", sda_oe, 0);
        chk(reg_we == 1'b0, "R1 reset no strobe", reg_we, 0);

        write_burst(16'h8010, 8'h3C, 3, "R6 step on");
        write_burst(16'h0020, 8'h71, 2, "R6 step off");
        write_burst(16'hFFFF, 8'hE0, 2, "R7 wrap");

        // R3: foreign identifier
        bus_start();
        send_byte({7'h55, 1'b0}, ack); chk(ack == 1'b1, "R3 no id ack", ack, 1);
        send_byte(8'h80, ack);         chk(ack == 1'b1, "R3 ignored byte", ack, 1);
        send_byte(8'h00, ack);         chk(ack == 1'b1, "R3 ignored byte", ack, 1);
        bus_stop();

        // R8: refused byte, then the same address accepts
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h80, ack); send_byte(8'h40, ack);
        ready_m = 1'b0;
        send_byte(8'h99, ack); chk(ack == 1'b1, "R8 nack when not ready", ack, 1);
        ready_m = 1'b1;
        exp_q.push_back('{a: 15'h0040, d: 8'h5A});
        send_byte(8'h5A, ack); chk(ack == 1'b0, "R8 ack when ready", ack, 0);
        bus_stop();
        half();
        chk(exp_q.size() == 0, "R8 same address after refusal", exp_q.size(), 0);

        // R11 / R9 / R10: set pointer, repeated start, read
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h81, ack); send_byte(8'h00, ack);
        bus_start();
        send_byte(8'hD5, ack); chk(ack == 1'b0, "R2 read id ack", ack, 0);
        recv_byte(b, 1'b0); chk(b == rd_f(15'h0100), "R11 R9 read byte0", b, rd_f(15'h0100));
        recv_byte(b, 1'b0); chk(b == rd_f(15'h0101), "R9 R6 read byte1", b, rd_f(15'h0101));
        recv_byte(b, 1'b1); chk(b == rd_f(15'h0102), "R9 R6 read byte2", b, rd_f(15'h0102));
        recv_byte(b, 1'b1); chk(b == 8'hFF, "R10 released after nack", b, 8'hFF);
        bus_stop();

        // R6: pointer kept across stop
        bus_start();
        send_byte(8'hD5, ack);
        recv_byte(b, 1'b1); chk(b == rd_f(15'h0103), "R6 read after stop", b, rd_f(15'h0103));
        bus_stop();

        // R6 / R11: stepping off on reads
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h02, ack); send_byte(8'h00, ack);
        bus_start();
        send_byte(8'hD5, ack);
        recv_byte(b, 1'b0); chk(b == rd_f(15'h0200), "R6 hold read0", b, rd_f(15'h0200));
        recv_byte(b, 1'b1); chk(b == rd_f(15'h0200), "R6 hold read1", b, rd_f(15'h0200));
        bus_stop();

        // R1: stop in mid-transaction, then a fresh identifier
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h80, ack);
        bus_stop();
        half();
        chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
        bus_start();
        send_byte(8'hD4, ack); chk(ack == 1'b0, "R1 fresh id after stop", ack, 0);
        send_byte(8'h80, ack); send_byte(8'h05, ack);
        exp_q.push_back('{a: 15'h0005, d: 8'h44});
        send_byte(8'h44, ack); chk(ack == 1'b0, "R1 data after restart", ack, 0);
        bus_stop();
        half();

        chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
        chk(oe_high_rise == 0, "R9 pull only while clock low", oe_high_rise, 0);
        summary();
    end
endmodule